// File: doc/BRIEF.md
# Indexed Address Generator with Page-Cross Penalty

This block forms effective addresses for an 8-bit processor that has a 16-bit address bus but only byte-wide adders. A single low-byte adder combines the base with an index, a signed branch offset or a constant one. A separate high-byte stage moves the upper byte up or down by one when the low-byte sum carries or borrows.

The adder runs in the cycle of the start strobe. Indexed loads and taken branches pay one extra cycle only when the high byte has to change. Indexed stores always pay that cycle. Zero-page indexing wraps inside page zero. Absolute jumps pass the target through unchanged. Program-counter increments use the high-byte stage in the same cycle, so they never stall.

The sequencer asserts a one-cycle done strobe when the address is ready. A penalty flag comes with it whenever the correction cycle was spent.

Top module: `idx_agen`

## Requirements
- R1: After reset `ea_o` is 0 and `done_o` and `pen_o` are low.
- R2: Mode 0 (indexed load): `ea_o` = base + unsigned index mod 2^16. With no carry out of the low byte, `done_o` pulses in the cycle after the start edge and `pen_o` stays low.
- R3: Mode 0 with a low-byte carry: `done_o` comes two cycles after the start edge with `pen_o` high, and the high byte of `ea_o` is incremented.
- R4: Mode 1 (indexed store): `ea_o` = base + index. `done_o` always comes two cycles after the start edge with `pen_o` high, whether or not the low byte carried.
- R5: Mode 2 (zero-page indexed): the high byte of `ea_o` is 0 and the low byte is (base low byte + index) mod 256. This mode takes one cycle and `pen_o` is low.
- R6: Mode 3 (taken branch): `idx_i` is a two's-complement offset and `ea_o` = base + sign-extended offset. The operation takes two cycles with `pen_o` high exactly when the high byte of `ea_o` differs from that of the base, which includes a borrow from a negative offset. Otherwise it takes one cycle.
- R7: Mode 4 (absolute jump): `ea_o` = base, one cycle, `pen_o` low.
- R8: Mode 5 (program-counter increment): `ea_o` = base + 1, with the carry into the high byte included (0xFFFF wraps to 0x0000). It takes one cycle and `pen_o` stays low.
- R9: `done_o` is a one-cycle pulse per accepted start. `pen_o` is never high without `done_o`.
- R10: A start strobe seen while a correction cycle is pending is ignored. It produces no done pulse and does not change `ea_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled on the rising edge |
| mode_i | input | 3 | Addressing mode (codes per R2-R8) |
| base_i | input | ADDR_W | Base address, branch origin or current program counter |
| idx_i | input | BYTE_W | Index or signed branch offset |
| ea_o | output | ADDR_W | Effective address |
| pen_o | output | 1 | Extra correction cycle was spent |
| done_o | output | 1 | Result valid pulse |

## Verification
A wrong carry or borrow decision is visible at once: the done pulse arrives one cycle early or late, and `pen_o` or the high byte of `ea_o` disagrees with the arithmetic. A stuck correction state shows up in the very next cycle as a missing or repeated done pulse, or as a swallowed start. Corrupted held state in the high-byte register shows up only on the next two-cycle operation, as a wrong upper byte.

// File: rtl/idx_agen_pkg.sv
package idx_agen_pkg;
  localparam logic [2:0] AM_IDX_LD = 3'd0;
  localparam logic [2:0] AM_IDX_ST = 3'd1;
  localparam logic [2:0] AM_ZP_X   = 3'd2;
  localparam logic [2:0] AM_REL    = 3'd3;
  localparam logic [2:0] AM_JMP    = 3'd4;
  localparam logic [2:0] AM_PC_INC = 3'd5;

  typedef enum logic [1:0] {HI_KEEP, HI_INC, HI_DEC} hi_op_e;
  typedef enum logic {ST_IDLE, ST_FIX} agen_st_e;
endpackage

// File: rtl/agen_lo_add.sv
module agen_lo_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o
);
  assign {carry_o, sum_o} = {1'b0, a_i} + {1'b0, b_i};
endmodule

// File: rtl/agen_hi_fix.sv
module agen_hi_fix
  import idx_agen_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] hi_i,
  input  hi_op_e       op_i,
  output logic [W-1:0] hi_o
);
  always_comb begin
    unique case (op_i)
      HI_INC:  hi_o = hi_i + W'(1);
      HI_DEC:  hi_o = hi_i - W'(1);
      default: hi_o = hi_i;
    endcase
  end
endmodule

// File: rtl/agen_decode.sv
module agen_decode
  import idx_agen_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [2:0]   mode_i,
  input  logic [W-1:0] idx_i,
  input  logic         carry_i,
  output logic [W-1:0] opnd_o,
  output hi_op_e       adj_o,
  output logic         need_fix_o,
  output logic         zero_hi_o
);
  logic neg;
  assign neg = idx_i[W-1];

  // operand depends on mode only; kept apart from the carry-dependent part
  always_comb begin
    unique case (mode_i)
      AM_IDX_LD, AM_IDX_ST, AM_ZP_X, AM_REL: opnd_o = idx_i;
      AM_PC_INC:                             opnd_o = W'(1);
      default:                               opnd_o = '0;
    endcase
  end

  always_comb begin
    adj_o      = HI_KEEP;
    need_fix_o = 1'b0;
    zero_hi_o  = 1'b0;
    unique case (mode_i)
      AM_IDX_LD: begin
        adj_o      = carry_i ? HI_INC : HI_KEEP;
        need_fix_o = carry_i;
      end
      AM_IDX_ST: begin
        adj_o      = carry_i ? HI_INC : HI_KEEP;
        need_fix_o = 1'b1;
      end
      AM_ZP_X: zero_hi_o = 1'b1;
      AM_REL: begin
        if (neg) adj_o = carry_i ? HI_KEEP : HI_DEC;
        else     adj_o = carry_i ? HI_INC  : HI_KEEP;
        need_fix_o = (adj_o != HI_KEEP);
      end
      AM_PC_INC: adj_o = carry_i ? HI_INC : HI_KEEP;
      default: ;
    endcase
  end
endmodule

// File: rtl/idx_agen.sv
module idx_agen
  import idx_agen_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        mode_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [BYTE_W-1:0] idx_i,
  output logic [ADDR_W-1:0] ea_o,
  output logic              pen_o,
  output logic              done_o
);
  localparam int HI_W = ADDR_W - BYTE_W;

  agen_st_e          state_q;
  hi_op_e            adj_q, adj_start, hi_op;
  logic [ADDR_W-1:0] ea_q;
  logic              done_q, pen_q, busy;
  logic [BYTE_W-1:0] opnd, lo_sum;
  logic              lo_carry, need_fix, zero_hi;
  logic [HI_W-1:0]   hi_src, hi_res;

  assign busy = (state_q == ST_FIX);

  agen_decode #(.W(BYTE_W)) u_dec (
    .mode_i     (mode_i),
    .idx_i      (idx_i),
    .carry_i    (lo_carry),
    .opnd_o     (opnd),
    .adj_o      (adj_start),
    .need_fix_o (need_fix),
    .zero_hi_o  (zero_hi)
  );

  agen_lo_add #(.W(BYTE_W)) u_lo (
    .a_i     (base_i[BYTE_W-1:0]),
    .b_i     (opnd),
    .sum_o   (lo_sum),
    .carry_o (lo_carry)
  );

  // high stage serves the correction cycle, or the same-cycle pc increment
  assign hi_src = busy ? ea_q[ADDR_W-1:BYTE_W] : base_i[ADDR_W-1:BYTE_W];
  assign hi_op  = busy ? adj_q : (need_fix ? HI_KEEP : adj_start);

  agen_hi_fix #(.W(HI_W)) u_hi (
    .hi_i (hi_src),
    .op_i (hi_op),
    .hi_o (hi_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      adj_q   <= HI_KEEP;
      ea_q    <= '0;
      done_q  <= 1'b0;
      pen_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      pen_q  <= 1'b0;
      if (busy) begin
        ea_q[ADDR_W-1:BYTE_W] <= hi_res;
        done_q  <= 1'b1;
        pen_q   <= 1'b1;
        state_q <= ST_IDLE;
      end else if (start_i) begin
        ea_q <= {(zero_hi ? {HI_W{1'b0}} : hi_res), lo_sum};
        if (need_fix) begin
          adj_q   <= adj_start;
          state_q <= ST_FIX;
        end else begin
          done_q <= 1'b1;
        end
      end
    end
  end

  assign ea_o   = ea_q;
  assign pen_o  = pen_q;
  assign done_o = done_q;
endmodule

// File: rtl/agen_chk.sv
module agen_chk #(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [2:0]        mode_i,
  input logic [ADDR_W-1:0] base_i,
  input logic [BYTE_W-1:0] idx_i,
  input logic [ADDR_W-1:0] ea_o,
  input logic              pen_o,
  input logic              done_o,
  input logic              busy
);
  logic go;
  assign go = start_i && !busy;

  AST_PEN_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pen_o |-> done_o);                                                   // R9
  AST_PEN_AFTER_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pen_o |-> !$past(done_o));                                           // R3
  AST_FIX_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> (!busy && done_o && pen_o));                                // R10
  AST_STORE_SLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go && mode_i == 3'd1) |=> !done_o);                                 // R4
  AST_ZP_PAGE0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go && mode_i == 3'd2) |=>
      (done_o && !pen_o && ea_o[ADDR_W-1:BYTE_W] == '0));               // R5
  AST_JMP_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go && mode_i == 3'd4) |=>
      (done_o && !pen_o && ea_o == $past(base_i)));                      // R7
  AST_PC_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go && mode_i == 3'd5) |=>
      (done_o && !pen_o && ea_o == ADDR_W'($past(base_i) + 1'b1)));      // R8
endmodule

bind idx_agen agen_chk #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/idx_agen_test.sv
`timescale 1ns/1ps
module idx_agen_test;
  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic [2:0]        mode_i = '0;
  logic [ADDR_W-1:0] base_i = '0;
  logic [BYTE_W-1:0] idx_i = '0;
  logic [ADDR_W-1:0] ea_o;
  logic              pen_o, done_o;

  int checks = 0;
  int failures = 0;

  always #2 clk_i = ~clk_i;

  idx_agen #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input string req, input logic [2:0] m,
                        input logic [15:0] b, input logic [7:0] i);
    logic [15:0] e;
    logic        p;
    int          lat;
    p = 1'b0;
    case (m)
      3'd0, 3'd1: begin
        e = b + {8'h00, i};
        p = (m == 3'd1) || ({1'b0, b[7:0]} + {1'b0, i} > 9'd255);
      end
      3'd2: e = {8'h00, 8'(b[7:0] + i)};
      3'd3: begin
        e = b + {{8{i[7]}}, i};
        p = (e[15:8] != b[15:8]);
      end
      3'd5: e = b + 16'd1;
      default: e = b;
    endcase
    @(negedge clk_i);
    start_i = 1'b1; mode_i = m; base_i = b; idx_i = i;
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 0;
    if (done_o) lat = 1;
    else begin
      @(negedge clk_i);
      if (done_o) lat = 2;
    end
    check({req, " latency"}, 32'(lat), p ? 32'd2 : 32'd1);
    check({req, " ea"}, 32'(ea_o), 32'(e));
    check({req, " pen"}, 32'(pen_o), 32'(p));
    @(negedge clk_i);
    check("R9 done pulse width", 32'(done_o), 32'd0);
    check("R9 pen without done", 32'(pen_o), 32'd0);
  endtask

  task automatic t_reset;
    check("R1 ea", 32'(ea_o), 32'd0);
    check("R1 done", 32'(done_o), 32'd0);
    check("R1 pen", 32'(pen_o), 32'd0);
  endtask

  task automatic t_load;
    run_op("R2 load no carry", 3'd0, 16'h2010, 8'h05);
    run_op("R2 load to FF", 3'd0, 16'h20F0, 8'h0F);
    run_op("R3 load carry", 3'd0, 16'h20F0, 8'h10);
    run_op("R3 load carry wrap", 3'd0, 16'hFFFF, 8'hFF);
  endtask

  task automatic t_store;
    run_op("R4 store no carry", 3'd1, 16'h3000, 8'h01);
    run_op("R4 store carry", 3'd1, 16'h30FF, 8'h01);
  endtask

  task automatic t_zp;
    run_op("R5 zp plain", 3'd2, 16'h4512, 8'h03);
    run_op("R5 zp wrap", 3'd2, 16'h00F0, 8'h20);
  endtask

  task automatic t_branch;
    run_op("R6 fwd same page", 3'd3, 16'h8010, 8'h20);
    run_op("R6 fwd cross", 3'd3, 16'h80F0, 8'h20);
    run_op("R6 back same page", 3'd3, 16'h8050, 8'hF0);
    run_op("R6 back borrow", 3'd3, 16'h8005, 8'hF0);
    run_op("R6 back to zero page", 3'd3, 16'h0100, 8'h80);
  endtask

  task automatic t_jump;
    run_op("R7 jump", 3'd4, 16'hC0FF, 8'hFF);
  endtask

  task automatic t_pc_inc;
    run_op("R8 pc inc", 3'd5, 16'h1234, 8'h00);
    run_op("R8 pc inc page", 3'd5, 16'h12FF, 8'h00);
    run_op("R8 pc inc wrap", 3'd5, 16'hFFFF, 8'h00);
  endtask

  task automatic t_busy_ignore;
    @(negedge clk_i);
    start_i = 1'b1; mode_i = 3'd0; base_i = 16'h10F0; idx_i = 8'h20;
    @(negedge clk_i);
    check("R10 no early done", 32'(done_o), 32'd0);
    mode_i = 3'd4; base_i = 16'hABCD;
    @(negedge clk_i);
    start_i = 1'b0;
    check("R10 fix done", 32'(done_o), 32'd1);
    check("R10 fix ea", 32'(ea_o), 32'h1110);
    @(negedge clk_i);
    check("R10 ignored start done", 32'(done_o), 32'd0);
    check("R10 ignored start ea", 32'(ea_o), 32'h1110);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_load();
    t_store();
    t_zp();
    t_branch();
    t_jump();
    t_pc_inc();
    t_busy_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule